// File: doc/BRIEF.md
# Wide-to-Narrow Clock-Crossing Result Queue

This block moves 128-bit results produced in a fast compute clock domain into a slower host-bus clock domain, where they are consumed as 32-bit words. The producer pushes one whole result per accepted transfer. The consumer takes one narrow word per accepted transfer. Each result therefore yields four consumer transfers, with the least-significant word first.

Both sides use valid/ready handshakes. A transfer happens on a rising edge of the side's own clock when valid and ready are both high. The producer must hold `s_valid` and `s_data` until `s_ready` is seen high. While `s_ready` is low the block takes nothing. The block holds `m_valid` and `m_data` steady until the consumer raises `m_ready`. The consumer may stall for any number of cycles.

Incoming results pass through a capture register before they reach the storage array. Outgoing words are presented from an output register. The write and read pointers cross between the domains in Gray code, through two-flop synchronizers. Each domain has its own active-low asynchronous reset.

Top module: `cdcw_fifo`

## Requirements
- R1: After reset, `s_ready` is 1 and `m_valid` is 0.
- R2: Results come out in the order they were accepted. Each result appears as four words on `m_data`: bits 31:0 first, then 63:32, then 95:64, then 127:96.
- R3: When the array is full, no stored entry is overwritten. Every accepted result is delivered intact.
- R4: When nothing is stored, `m_valid` stays 0 even if `m_ready` is held high, and no read pointer moves.
- R5: With the consumer idle, exactly DEPTH+1 results are accepted before `s_ready` falls. DEPTH entries go to the array and one waits in the capture register.
- R6: While `m_valid` is 1 and `m_ready` is 0, `m_valid` and `m_data` hold their values.
- R7: Data offered while `s_ready` is 0 is ignored. It never appears on `m_data`.
- R8: An entry's array slot is released only when its fourth word moves into the output register. Suppose the queue is full and the consumer has taken just two words of the oldest entry. `s_ready` then stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Producer-side clock |
| wrst_n | input | 1 | Producer-side asynchronous reset, active low |
| s_valid | input | 1 | Producer offers a result |
| s_ready | output | 1 | Block can accept a result |
| s_data | input | IN_W | Result to store |
| rclk | input | 1 | Consumer-side clock |
| rrst_n | input | 1 | Consumer-side asynchronous reset, active low |
| m_valid | output | 1 | Output register holds a word |
| m_ready | input | 1 | Consumer takes the word |
| m_data | output | OUT_W | Current narrow word |

## Verification
Two functions can coincide: a new result is accepted into a full queue at the moment the reader frees a slot. The bench provokes this by filling the queue with the reader stalled, then letting the reader drain while the writer keeps `s_valid` high on an unrelated clock, so acceptances land right on slot releases. The result is judged word by word against a scoreboard built from the accepted results. Any lost, repeated or overwritten entry shows up as an ordering or value mismatch. The same scoreboard also catches any ignored write that wrongly leaks into the output.

// File: rtl/cdcw_pkg.sv
package cdcw_pkg;
  localparam int SYNC_STAGES = 2;

  function automatic int words_per_entry(input int in_w, input int out_w);
    return in_w / out_w;
  endfunction
endpackage

// File: rtl/cdcw_sync.sv
module cdcw_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  import cdcw_pkg::*;
  logic [W-1:0] stage [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[SYNC_STAGES-1];
endmodule

// File: rtl/cdcw_mem.sv
module cdcw_mem #(
  parameter int AW = 4,
  parameter int DW = 128
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] slots [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) slots[waddr] <= wdata;
  end

  assign rdata = slots[raddr];
endmodule

// File: rtl/cdcw_wr.sv
module cdcw_wr #(
  parameter int AW = 4,
  parameter int DW = 128
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic [AW:0]   rgray_sync,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW:0]   wgray
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_XOR = PW'(3) << (PW - 2);

  logic [PW-1:0] wbin, wbin_nxt;
  logic          stg_vld;
  logic [DW-1:0] stg_data;
  logic          full, commit, accept;

  assign full     = ((wgray ^ rgray_sync) == FULL_XOR);
  assign commit   = stg_vld && !full;
  assign s_ready  = !stg_vld || !full;
  assign accept   = s_valid && s_ready;
  assign wbin_nxt = wbin + PW'(commit);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      stg_vld  <= 1'b0;
      stg_data <= '0;
      wbin     <= '0;
      wgray    <= '0;
    end else begin
      if (accept) stg_data <= s_data;
      if (accept)      stg_vld <= 1'b1;
      else if (commit) stg_vld <= 1'b0;
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  assign mem_we    = commit;
  assign mem_waddr = wbin[AW-1:0];
  assign mem_wdata = stg_data;

  // R3: a full queue never advances the write pointer
  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
    full |=> $stable(wgray));
  // R2: crossing pointer changes in at most one bit per step
  p_wgray_step_r2: assert property (@(posedge wclk) disable iff (!wrst_n)
    1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));
  // R7: a refused offer leaves the capture register untouched
  p_refused_r7: assert property (@(posedge wclk) disable iff (!wrst_n)
    (s_valid && !s_ready) |=> $stable(stg_data));
endmodule

// File: rtl/cdcw_rd.sv
module cdcw_rd #(
  parameter int AW    = 4,
  parameter int IN_W  = 128,
  parameter int OUT_W = 32
) (
  input  logic             rclk,
  input  logic             rrst_n,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [OUT_W-1:0] m_data,
  input  logic [AW:0]      wgray_sync,
  output logic [AW-1:0]    mem_raddr,
  input  logic [IN_W-1:0]  mem_rdata,
  output logic [AW:0]      rgray
);
  import cdcw_pkg::*;
  localparam int PW    = AW + 1;
  localparam int WORDS = words_per_entry(IN_W, OUT_W);
  localparam int SW    = $clog2(WORDS);

  logic [PW-1:0] rbin, rbin_nxt;
  logic [SW-1:0] sel;
  logic          empty, load, last;

  assign empty    = (rgray == wgray_sync);
  assign load     = !empty && (!m_valid || m_ready);
  assign last     = (sel == SW'(WORDS - 1));
  assign rbin_nxt = rbin + PW'(load && last);

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      sel     <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      if (load) begin
        m_data <= mem_rdata[sel*OUT_W +: OUT_W];
        sel    <= last ? '0 : sel + SW'(1);
      end
      if (load)         m_valid <= 1'b1;
      else if (m_ready) m_valid <= 1'b0;
      rbin  <= rbin_nxt;
      rgray <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end

  assign mem_raddr = rbin[AW-1:0];

  // R4: nothing stored, read pointer frozen
  p_no_underflow_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty |=> $stable(rgray));
  // R6: stalled output holds
  p_hold_out_r6: assert property (@(posedge rclk) disable iff (!rrst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  // R8: slot released only with the final word of an entry
  p_release_last_r8: assert property (@(posedge rclk) disable iff (!rrst_n)
    !(load && last) |=> $stable(rgray));
  // R2: crossing pointer changes in at most one bit per step
  p_rgray_step_r2: assert property (@(posedge rclk) disable iff (!rrst_n)
    1'b1 |=> ($countones(rgray ^ $past(rgray)) <= 1));
endmodule

// File: rtl/cdcw_fifo.sv
module cdcw_fifo #(
  parameter int DEPTH = 16,
  parameter int IN_W  = 128,
  parameter int OUT_W = 32
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [IN_W-1:0]  s_data,
  input  logic             rclk,
  input  logic             rrst_n,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [OUT_W-1:0] m_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0]   wgray, rgray, wgray_sync, rgray_sync;
  logic            mem_we;
  logic [AW-1:0]   mem_waddr, mem_raddr;
  logic [IN_W-1:0] mem_wdata, mem_rdata;

  initial begin
    a_depth_pow2: assert (DEPTH >= 4 && (1 << AW) == DEPTH);
    a_width_ratio: assert (IN_W % OUT_W == 0 && IN_W / OUT_W >= 2);
  end

  cdcw_wr #(.AW(AW), .DW(IN_W)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .rgray_sync(rgray_sync), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .wgray(wgray));

  cdcw_mem #(.AW(AW), .DW(IN_W)) u_mem (
    .wclk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata));

  cdcw_sync #(.W(PW)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_sync));

  cdcw_sync #(.W(PW)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_sync));

  cdcw_rd #(.AW(AW), .IN_W(IN_W), .OUT_W(OUT_W)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .wgray_sync(wgray_sync), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .rgray(rgray));
endmodule

// File: tb/sim_cdcw_fifo.sv
module sim_cdcw_fifo;
  localparam int DEPTH = 16;
  localparam int IN_W  = 128;
  localparam int OUT_W = 32;
  localparam int WORDS = IN_W / OUT_W;

  logic             wclk = 1'b0, rclk = 1'b0;
  logic             wrst_n = 1'b0, rrst_n = 1'b0;
  logic             s_valid = 1'b0, m_ready = 1'b0;
  logic [IN_W-1:0]  s_data = '0;
  logic             s_ready, m_valid;
  logic [OUT_W-1:0] m_data;

  int n_checks = 0;
  int n_fails  = 0;
  logic [OUT_W-1:0] expq [$];

  always #10 wclk = ~wclk;   // 50 MHz producer clock
  always #33 rclk = ~rclk;   // unrelated slower consumer clock

  cdcw_fifo #(.DEPTH(DEPTH), .IN_W(IN_W), .OUT_W(OUT_W)) u0 (
    .wclk(wclk), .wrst_n(wrst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .rclk(rclk), .rrst_n(rrst_n), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [IN_W-1:0] mk(input int k);
    logic [IN_W-1:0] v;
    for (int i = 0; i < WORDS; i++) v[i*OUT_W +: OUT_W] = {16'(k), 8'(i), 8'h5A};
    return v;
  endfunction

  task automatic push_exp(input logic [IN_W-1:0] v);
    for (int i = 0; i < WORDS; i++) expq.push_back(v[i*OUT_W +: OUT_W]);
  endtask

  // Offer one result and wait until it is taken.
  task automatic wr_entry(input int k);
    int guard = 0;
    @(negedge wclk);
    s_valid = 1'b1;
    s_data  = mk(k);
    while (!s_ready && guard < 5000) begin @(negedge wclk); guard++; end
    chk(s_ready, "R3", "write accepted", longint'(s_ready), 1);
    @(posedge wclk);
    push_exp(mk(k));
    #1 s_valid = 1'b0;
  endtask

  // Take one word after stalling for the given number of cycles.
  task automatic rd_word(input int stall);
    int guard = 0;
    logic [OUT_W-1:0] held, exp;
    m_ready = 1'b0;
    @(negedge rclk);
    while (!m_valid && guard < 5000) begin @(negedge rclk); guard++; end
    held = m_data;
    for (int s = 0; s < stall; s++) begin
      @(negedge rclk);
      chk(m_valid && m_data == held, "R6", "stalled word held", longint'(m_data), longint'(held));
    end
    exp = (expq.size() > 0) ? expq.pop_front() : 32'hFFFF_FFFF;
    chk(m_valid && m_data == exp, "R2", "word order/value", longint'(m_data), longint'(exp));
    m_ready = 1'b1;
    @(posedge rclk);
    #1 m_ready = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge wclk);
    chk(s_ready == 1'b1, "R1", "s_ready after reset", longint'(s_ready), 1);
    @(negedge rclk);
    chk(m_valid == 1'b0, "R1", "m_valid after reset", longint'(m_valid), 0);
  endtask

  task automatic t_empty_read;
    m_ready = 1'b1;
    repeat (10) @(negedge rclk);
    chk(m_valid == 1'b0, "R4", "no word from empty queue", longint'(m_valid), 0);
    m_ready = 1'b0;
  endtask

  task automatic t_single;
    wr_entry(1);
    for (int i = 0; i < WORDS; i++) rd_word(i);
    repeat (12) @(negedge rclk);
    chk(m_valid == 1'b0, "R8", "entry ends after four words", longint'(m_valid), 0);
    chk(expq.size() == 0, "R2", "scoreboard drained", longint'(expq.size()), 0);
  endtask

  task automatic t_fill_and_refuse;
    int taken = 0;
    for (int a = 0; a < DEPTH + 8; a++) begin
      @(negedge wclk);
      if (!s_ready) break;
      s_valid = 1'b1;
      s_data  = mk(100 + a);
      @(posedge wclk);
      push_exp(mk(100 + a));
      taken++;
      #1 s_valid = 1'b0;
    end
    repeat (20) @(negedge wclk);
    chk(taken == DEPTH + 1, "R5", "results taken before back-pressure", longint'(taken), DEPTH + 1);
    chk(s_ready == 1'b0, "R5", "s_ready low when full", longint'(s_ready), 0);
    // offers while refused must vanish
    @(negedge wclk);
    s_valid = 1'b1;
    s_data  = {WORDS{32'hDEAD_BEEF}};
    repeat (6) @(negedge wclk);
    chk(s_ready == 1'b0, "R7", "still refusing", longint'(s_ready), 0);
    s_valid = 1'b0;
    // two words out: slot of the oldest entry still held
    rd_word(0);
    rd_word(2);
    repeat (20) @(negedge wclk);
    chk(s_ready == 1'b0, "R8", "slot held mid-entry", longint'(s_ready), 0);
    while (expq.size() > 0) rd_word(0);
    repeat (12) @(negedge rclk);
    chk(m_valid == 1'b0, "R7", "no refused data emitted", longint'(m_valid), 0);
    chk(s_ready == 1'b1, "R3", "room again after drain", longint'(s_ready), 1);
  endtask

  task automatic t_concurrent;
    fork
      begin
        for (int i = 0; i < DEPTH; i++) wr_entry(200 + i);
      end
    join
    fork
      begin
        for (int i = 0; i < 2 * DEPTH; i++) wr_entry(300 + i);
      end
      begin
        repeat (5) @(negedge rclk);
        for (int i = 0; i < 3 * DEPTH * WORDS; i++) rd_word(i % 3 == 0 ? 1 : 0);
      end
    join
    repeat (12) @(negedge rclk);
    chk(expq.size() == 0, "R3", "all results delivered", longint'(expq.size()), 0);
    chk(m_valid == 1'b0, "R4", "idle after drain", longint'(m_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge wclk);
    #3 wrst_n = 1'b1;
    repeat (2) @(posedge rclk);
    #3 rrst_n = 1'b1;
    t_reset();
    t_empty_read();
    t_single();
    t_fill_and_refuse();
    t_concurrent();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule